// File: doc/BRIEF.md
# Prioritized Cache Request Arbiter

This block sits at the entrance of a cache main pipeline. Each cycle it picks one task from four request sources: an MSHR task queue and three upstream coherence channels, C, B and A. It passes the task through two register stages. A stall stage ahead of arbitration (s0) holds off the MSHR queue. The arbitration stage (s1) starts the directory lookup for the winning task. A spacing stage (s2) keeps tasks at least two cycles apart, because the SRAMs behind the pipeline need every access held for two cycles. The spacing stage also tells the data buffers whether the refill or the release buffer is to be read.

Every source presents a valid/ready pair with an address and a four-bit attribute word. A transfer happens in a cycle where both valid and ready are high. Ready depends on valid and on the block inputs in the same cycle. The task output to the main pipeline is also valid/ready. Once the block raises valid, it holds valid and the task contents steady until the pipeline raises ready. When the pipeline does not accept, the s2 register stays full. The s1 register then stays full, and the block stops granting new source requests. The stall inputs, the per-set block inputs and the directory and buffer read strobes are plain level signals with no handshake.

Top module: `cache_req_arbiter`

## Requirements
- R1: Source index 0 is the MSHR queue, 1 is channel C, 2 is channel B and 3 is channel A. Among the eligible requesters the lowest index wins. At most one bit of `req_ready` is high, and only a requester that is valid can see ready.
- R2: `mshr_stall` is high whenever any of `blk_grant_buf`, `blk_up_c`, `blk_txdat`, `blk_txrsp` or `blk_txreq` is high. While `mshr_stall` is high, source 0 never sees ready.
- R3: Attribute bit 0 marks a task that needs a directory read. Suppose source 0 is valid with bit 0 set, `mshr_stall` is low, and the source still does not see ready. Then `mshr_stall` is high in the next cycle.
- R4: The set index of an address is bits `SET_LSB+SET_W-1` down to `SET_LSB`. While `set_blk_valid` is high, sources 0 and 1 are not eligible if their set index equals `set_blk_idx`. Sources 2 and 3 ignore that input.
- R5: `dir_rd_valid` is high in the cycle a task is accepted from a source, and only when its attribute bit 0 is set. `dir_rd_set` then carries that task's set index.
- R6: An accepted task enters the s1 register. When s2 cannot take it, the task stays in s1, and no source sees ready until s1 empties or moves on in the same cycle.
- R7: Tasks never move from s1 into s2 in two consecutive cycles. With the pipeline always ready, a continuous MSHR stream appears on `pipe_valid` high every other cycle.
- R8: While `pipe_valid` is high and `pipe_ready` is low, the next cycle still has `pipe_valid` high with the same `pipe_addr`, `pipe_src` and `pipe_attr`.
- R9: In the first cycle a task sits in s2, `buf_rd_valid` is high with `buf_rd_release` = 1 if either of these holds: the source is 0 and attribute bit 2 (uses probe data) is set, or the source is not 0 and attribute bit 3 (snoop nested with a write-back) is set. This case takes precedence over R10.
- R10: Otherwise, in that first s2 cycle, `buf_rd_valid` is high with `buf_rd_release` = 0 if either of these holds: attribute bit 1 (replacement write-back or eviction) is set, or the source is 3 and attribute bit 2 is clear. In every other case, and in later s2 cycles, `buf_rd_valid` is low.
- R11: While `rst_n` is low, the s1 and s2 stages empty, the spacing flag and the re-stall flag clear, and `pipe_valid` and `buf_rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 4 | Per-source request valid, index 0 = MSHR, 1 = C, 2 = B, 3 = A |
| req_ready | output | 4 | Per-source grant/ready |
| req_addr | input | 4*ADDR_W | Per-source address, source i at bits i*ADDR_W upward |
| req_attr | input | 16 | Per-source attributes: bit0 dir read, bit1 replacement, bit2 probe data, bit3 nested snoop |
| blk_grant_buf | input | 1 | Grant buffer stall request |
| blk_up_c | input | 1 | Upstream C stall request |
| blk_txdat | input | 1 | Downstream data channel stall request |
| blk_txrsp | input | 1 | Downstream response channel stall request |
| blk_txreq | input | 1 | Downstream request channel stall request |
| mshr_stall | output | 1 | Backpressure to the MSHR queue |
| set_blk_valid | input | 1 | Pipeline may write the directory of a set |
| set_blk_idx | input | SET_W | Set under possible directory write |
| dir_rd_valid | output | 1 | Directory read strobe |
| dir_rd_set | output | SET_W | Directory read set index |
| buf_rd_valid | output | 1 | Data buffer read strobe |
| buf_rd_release | output | 1 | 1 = release buffer, 0 = refill buffer |
| pipe_valid | output | 1 | Task valid to the main pipeline |
| pipe_ready | input | 1 | Main pipeline accepts the task |
| pipe_addr | output | ADDR_W | Task address |
| pipe_src | output | 2 | Task source index |
| pipe_attr | output | 4 | Task attributes |

## Verification
The one-cycle re-stall is the hardest behaviour to reach from the ports. It needs an MSHR task with the directory bit that loses in s1 while the stall inputs are all low. The stimulus gets there by raising a set block that matches the MSHR address for exactly one cycle and then removing it. The next cycle must show the stall with no stall input high, and the cycle after that must show the grant. Another hard case is a task held in s1 behind a stuck s2. This is reached by keeping `pipe_ready` low while a source streams tasks with changing addresses, and the older address must leave first once ready returns.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned NSRC   = 4;
  localparam int unsigned SRC_W  = 2;
  localparam int unsigned ATTR_W = 4;

  localparam int unsigned SRC_MSHR = 0;
  localparam int unsigned SRC_C    = 1;
  localparam int unsigned SRC_B    = 2;
  localparam int unsigned SRC_A    = 3;

  localparam int unsigned AT_DIR   = 0;
  localparam int unsigned AT_REPL  = 1;
  localparam int unsigned AT_PROBE = 2;
  localparam int unsigned AT_NEST  = 3;

  localparam int unsigned NBLK = 5;

  typedef struct packed {
    logic [SRC_W-1:0]  src;
    logic [ATTR_W-1:0] attr;
  } tsk_meta_t;
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N-1:0] taken;

  assign taken[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_pick
    assign gnt[i] = req[i] && !taken[i];
    if (i < N - 1) begin : g_chain
      assign taken[i+1] = taken[i] || req[i];
    end
  end
endmodule

// File: rtl/arb_stall_gen.sv
module arb_stall_gen #(
  parameter int unsigned NB = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] blk,
  input  logic          mshr_valid,
  input  logic          mshr_dir,
  input  logic          mshr_ready,
  output logic          stall
);
  logic lost_q;

  assign stall = (|blk) || lost_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lost_q <= 1'b0;
    else        lost_q <= mshr_valid && mshr_dir && !stall && !mshr_ready;
  end
endmodule

// File: rtl/arb_buf_route.sv
module arb_buf_route
  import arb_pkg::*;
(
  input  logic [SRC_W-1:0]  src,
  input  logic [ATTR_W-1:0] attr,
  output logic              need,
  output logic              use_release
);
  logic is_mshr, is_a, rel, refl;

  always_comb begin
    is_mshr     = (src == SRC_W'(SRC_MSHR));
    is_a        = (src == SRC_W'(SRC_A));
    rel         = (is_mshr && attr[AT_PROBE]) || (!is_mshr && attr[AT_NEST]);
    refl        = attr[AT_REPL] || (is_a && !attr[AT_PROBE]);
    need        = rel || refl;
    use_release = rel;
  end
endmodule

// File: rtl/cache_req_arbiter.sv
module cache_req_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned SET_LSB = 6,
  parameter int unsigned SET_W   = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          req_valid,
  output logic [NSRC-1:0]          req_ready,
  input  logic [NSRC*ADDR_W-1:0]   req_addr,
  input  logic [NSRC*ATTR_W-1:0]   req_attr,
  input  logic                     blk_grant_buf,
  input  logic                     blk_up_c,
  input  logic                     blk_txdat,
  input  logic                     blk_txrsp,
  input  logic                     blk_txreq,
  output logic                     mshr_stall,
  input  logic                     set_blk_valid,
  input  logic [SET_W-1:0]         set_blk_idx,
  output logic                     dir_rd_valid,
  output logic [SET_W-1:0]         dir_rd_set,
  output logic                     buf_rd_valid,
  output logic                     buf_rd_release,
  output logic                     pipe_valid,
  input  logic                     pipe_ready,
  output logic [ADDR_W-1:0]        pipe_addr,
  output logic [SRC_W-1:0]         pipe_src,
  output logic [ATTR_W-1:0]        pipe_attr
);
  logic [NSRC-1:0]   elig;
  logic [NSRC-1:0]   pick;
  logic              accept;
  logic [ADDR_W-1:0] win_addr;
  tsk_meta_t         win_meta;

  logic              s1_valid, s2_valid, gap_q;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  tsk_meta_t         s1_meta, s2_meta;
  logic              s1_free, s2_free, s1_adv;
  logic              route_need, route_rel;

  // s0: backpressure toward the MSHR queue
  arb_stall_gen #(.NB(NBLK)) u_stall (
    .clk        (clk),
    .rst_n      (rst_n),
    .blk        ({blk_grant_buf, blk_up_c, blk_txdat, blk_txrsp, blk_txreq}),
    .mshr_valid (req_valid[SRC_MSHR]),
    .mshr_dir   (req_attr[SRC_MSHR*ATTR_W + AT_DIR]),
    .mshr_ready (req_ready[SRC_MSHR]),
    .stall      (mshr_stall)
  );

  // s1: eligibility, with set blocking on the MSHR and C sources
  for (genvar i = 0; i < NSRC; i++) begin : g_elig
    if (i == SRC_MSHR || i == SRC_C) begin : g_setchk
      logic set_hit;
      assign set_hit = set_blk_valid &&
                       (req_addr[i*ADDR_W + SET_LSB +: SET_W] == set_blk_idx);
      if (i == SRC_MSHR) begin : g_m
        assign elig[i] = req_valid[i] && !mshr_stall && !set_hit;
      end else begin : g_c
        assign elig[i] = req_valid[i] && !set_hit;
      end
    end else begin : g_free
      assign elig[i] = req_valid[i];
    end
  end

  arb_prio_pick #(.N(NSRC)) u_pick (
    .req (elig),
    .gnt (pick)
  );

  assign s2_free   = !s2_valid || pipe_ready;
  assign s1_adv    = s1_valid && s2_free && !gap_q;
  assign s1_free   = !s1_valid || s1_adv;
  assign req_ready = pick & {NSRC{s1_free}};
  assign accept    = |req_ready;

  always_comb begin
    win_addr = '0;
    win_meta = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req_ready[i]) begin
        win_addr      = req_addr[i*ADDR_W +: ADDR_W];
        win_meta.attr = req_attr[i*ATTR_W +: ATTR_W];
        win_meta.src  = SRC_W'(i);
      end
    end
  end

  assign dir_rd_valid = accept && win_meta.attr[AT_DIR];
  assign dir_rd_set   = win_addr[SET_LSB +: SET_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else if (accept) begin
      s1_valid <= 1'b1;
    end else if (s1_adv) begin
      s1_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_addr <= win_addr;
      s1_meta <= win_meta;
    end
  end

  // s2: two-cycle spacing and buffer choice
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      gap_q    <= 1'b0;
    end else begin
      gap_q <= s1_adv;
      if (s1_adv)          s2_valid <= 1'b1;
      else if (pipe_ready) s2_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_adv) begin
      s2_addr <= s1_addr;
      s2_meta <= s1_meta;
    end
  end

  arb_buf_route u_route (
    .src         (s2_meta.src),
    .attr        (s2_meta.attr),
    .need        (route_need),
    .use_release (route_rel)
  );

  assign buf_rd_valid   = s2_valid && gap_q && route_need;
  assign buf_rd_release = route_rel;

  assign pipe_valid = s2_valid;
  assign pipe_addr  = s2_addr;
  assign pipe_src   = s2_meta.src;
  assign pipe_attr  = s2_meta.attr;
endmodule

// File: rtl/cache_req_arbiter_chk.sv
module cache_req_arbiter_chk #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned SET_LSB = 6,
  parameter int unsigned SET_W   = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        req_ready,
  input logic              mshr_valid,
  input logic              mshr_dir,
  input logic [ADDR_W-1:0] mshr_addr,
  input logic [ADDR_W-1:0] c_addr,
  input logic              mshr_stall,
  input logic              set_blk_valid,
  input logic [SET_W-1:0]  set_blk_idx,
  input logic              pipe_valid,
  input logic              pipe_ready,
  input logic [ADDR_W-1:0] pipe_addr,
  input logic              s1_adv
);
  a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  a_r2_stall_blocks_mshr: assert property (@(posedge clk) disable iff (!rst_n)
    mshr_stall |-> !req_ready[0]);

  a_r3_restall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mshr_valid && mshr_dir && !mshr_stall && !req_ready[0]))
      |-> mshr_stall);

  a_r4_set_block_mshr: assert property (@(posedge clk) disable iff (!rst_n)
    (set_blk_valid && mshr_addr[SET_LSB +: SET_W] == set_blk_idx) |-> !req_ready[0]);

  a_r4_set_block_c: assert property (@(posedge clk) disable iff (!rst_n)
    (set_blk_valid && c_addr[SET_LSB +: SET_W] == set_blk_idx) |-> !req_ready[1]);

  a_r7_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    s1_adv |=> !s1_adv);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_valid && !pipe_ready) |=> (pipe_valid && $stable(pipe_addr)));
endmodule

bind cache_req_arbiter cache_req_arbiter_chk #(
  .ADDR_W (ADDR_W),
  .SET_LSB(SET_LSB),
  .SET_W  (SET_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .mshr_valid   (req_valid[0]),
  .mshr_dir     (req_attr[0]),
  .mshr_addr    (req_addr[ADDR_W-1:0]),
  .c_addr       (req_addr[2*ADDR_W-1:ADDR_W]),
  .mshr_stall   (mshr_stall),
  .set_blk_valid(set_blk_valid),
  .set_blk_idx  (set_blk_idx),
  .pipe_valid   (pipe_valid),
  .pipe_ready   (pipe_ready),
  .pipe_addr    (pipe_addr),
  .s1_adv       (s1_adv)
);

// File: tb/cache_req_arbiter_tb_top.sv
`timescale 1ns/1ps
module cache_req_arbiter_tb_top;
  localparam int ADDR_W = 16;
  localparam int SET_LSB = 6;
  localparam int SET_W = 7;
  localparam logic [ADDR_W-1:0] A1 = 16'h1240;
  localparam logic [ADDR_W-1:0] A2 = 16'h2a80;

  // fields: [15:12] valid mask, [11:8] attr, [7] txreq stall, [6] set block,
  //         [5:2] expected ready, [1] expected buf read, [0] expected release
  localparam int NV = 13;
  localparam logic [15:0] VEC [0:NV-1] = '{
    16'b1111_0001_0_0_0001_0_0, // R1 R5
    16'b1110_0100_0_0_0010_0_0, // R1
    16'b1100_0000_0_0_0100_0_0, // R1
    16'b1000_0000_0_0_1000_1_0, // R10
    16'b1000_0100_0_0_1000_0_0, // R10 no read
    16'b0001_0100_0_0_0001_1_1, // R9
    16'b0001_0010_0_0_0001_1_0, // R10
    16'b0100_1000_0_0_0100_1_1, // R9
    16'b1111_0000_1_0_0010_0_0, // R2
    16'b1111_0000_0_1_0100_0_0, // R4
    16'b0011_0000_0_1_0000_0_0, // R4
    16'b0001_0110_0_0_0001_1_1, // R9 over R10
    16'b1000_0010_0_0_1000_1_0  // R10
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] req_valid = '0;
  logic [3:0] req_ready;
  logic [4*ADDR_W-1:0] req_addr = '0;
  logic [15:0] req_attr = '0;
  logic [4:0] blk = '0;
  logic mshr_stall;
  logic set_blk_valid = 1'b0;
  logic [SET_W-1:0] set_blk_idx = '0;
  logic dir_rd_valid;
  logic [SET_W-1:0] dir_rd_set;
  logic buf_rd_valid, buf_rd_release, pipe_valid;
  logic pipe_ready = 1'b0;
  logic [ADDR_W-1:0] pipe_addr;
  logic [1:0] pipe_src;
  logic [3:0] pipe_attr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cache_req_arbiter #(.ADDR_W(ADDR_W), .SET_LSB(SET_LSB), .SET_W(SET_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_attr(req_attr),
    .blk_grant_buf(blk[4]), .blk_up_c(blk[3]), .blk_txdat(blk[2]),
    .blk_txrsp(blk[1]), .blk_txreq(blk[0]), .mshr_stall(mshr_stall),
    .set_blk_valid(set_blk_valid), .set_blk_idx(set_blk_idx),
    .dir_rd_valid(dir_rd_valid), .dir_rd_set(dir_rd_set),
    .buf_rd_valid(buf_rd_valid), .buf_rd_release(buf_rd_release),
    .pipe_valid(pipe_valid), .pipe_ready(pipe_ready), .pipe_addr(pipe_addr),
    .pipe_src(pipe_src), .pipe_attr(pipe_attr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    req_valid = '0; blk = '0; set_blk_valid = 1'b0; pipe_ready = 1'b1;
    repeat (5) cyc();
    pipe_ready = 1'b0;
    cyc();
  endtask

  initial begin
    @(negedge clk);
    req_addr = {4{A1}};
    set_blk_idx = A1[SET_LSB +: SET_W];
    repeat (2) cyc();
    // R11: reset state
    chk("R11 pipe_valid in reset", pipe_valid, 0);
    chk("R11 buf_rd_valid in reset", buf_rd_valid, 0);
    rst_n = 1'b1;
    cyc();
    chk("R11 pipe_valid after reset", pipe_valid, 0);
    chk("R2 stall idle", mshr_stall, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [3:0] eg;
      int es;
      eg = VEC[v][5:2];
      es = 0;
      for (int k = 0; k < 4; k++) if (eg[k]) es = k;
      req_valid = VEC[v][15:12];
      req_attr = {4{VEC[v][11:8]}};
      blk[0] = VEC[v][7];
      set_blk_valid = VEC[v][6];
      #1;
      chk($sformatf("R1 R2 R4 ready vec%0d", v), req_ready, eg);
      chk($sformatf("R5 dir_rd_valid vec%0d", v), dir_rd_valid, (|eg) && VEC[v][8]);
      if (VEC[v][8] && (|eg))
        chk($sformatf("R5 dir_rd_set vec%0d", v), dir_rd_set, A1[SET_LSB +: SET_W]);
      cyc();
      req_valid = '0; blk = '0; set_blk_valid = 1'b0;
      cyc();
      chk($sformatf("R6 pipe_valid vec%0d", v), pipe_valid, |eg);
      if (|eg) begin
        chk($sformatf("R1 pipe_src vec%0d", v), pipe_src, es);
        chk($sformatf("R9 R10 buf_rd_valid vec%0d", v), buf_rd_valid, VEC[v][1]);
        if (VEC[v][1])
          chk($sformatf("R9 R10 buf_rd_release vec%0d", v), buf_rd_release, VEC[v][0]);
      end
      pipe_ready = 1'b1;
      cyc();
      pipe_ready = 1'b0;
      chk($sformatf("R10 buf read once vec%0d", v), buf_rd_valid, 0);
      cyc();
    end
    req_attr = '0;

    // R2: each stall input alone
    for (int b = 0; b < 5; b++) begin
      blk = 5'(1 << b);
      req_valid = 4'b0001;
      #1;
      chk($sformatf("R2 stall from input %0d", b), mshr_stall, 1);
      chk($sformatf("R2 mshr held input %0d", b), req_ready[0], 0);
      blk = '0; req_valid = '0;
      cyc();
    end

    // R3: one-cycle re-stall after a lost directory-read task
    req_attr = 16'h0001;
    req_valid = 4'b0001;
    set_blk_valid = 1'b1;
    #1;
    chk("R4 mshr set-blocked", req_ready[0], 0);
    chk("R3 no stall yet", mshr_stall, 0);
    cyc();
    set_blk_valid = 1'b0;
    #1;
    chk("R3 restall", mshr_stall, 1);
    chk("R3 mshr held", req_ready[0], 0);
    cyc();
    chk("R3 restall clears", mshr_stall, 0);
    chk("R3 mshr granted", req_ready[0], 1);
    drain();
    req_attr = '0;

    // R7: spacing with an always-ready pipeline
    req_valid = 4'b0001;
    pipe_ready = 1'b1;
    cyc(); // accept T1
    for (int k = 0; k < 6; k++) begin
      cyc();
      chk($sformatf("R7 spacing step %0d", k), pipe_valid, (k % 2) == 0);
    end
    drain();

    // R6 R8: stuck pipeline holds s2 and s1
    req_addr[ADDR_W-1:0] = A1;
    req_valid = 4'b0001;
    cyc(); // T1 accepted
    req_addr[ADDR_W-1:0] = A2;
    cyc(); // T1 to s2, T2 accepted
    cyc();
    chk("R6 s1 full no grant", req_ready[0], 0);
    cyc();
    chk("R8 pipe_valid held", pipe_valid, 1);
    chk("R8 pipe_addr held", pipe_addr, A1);
    chk("R6 still no grant", req_ready[0], 0);
    pipe_ready = 1'b1;
    cyc();
    req_valid = '0;
    chk("R6 held task follows", pipe_addr, A2);
    drain();

    // R11: reset with tasks in flight
    req_valid = 4'b0001;
    repeat (3) cyc();
    req_valid = '0;
    rst_n = 1'b0;
    cyc();
    chk("R11 pipe cleared", pipe_valid, 0);
    chk("R11 buf read cleared", buf_rd_valid, 0);
    rst_n = 1'b1;
    req_valid = 4'b0001;
    #1;
    chk("R11 s1 empty after reset", req_ready[0], 1);
    drain();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule